// File: doc/BRIEF.md
# Receive Descriptor Write-Back Coalescer

This block sits between a receive engine and a memory write port. The engine hands it finished 16-byte receive descriptors, one per cycle, over a valid/ready handshake. The block gathers them in an accumulation bank. It then writes them back to host memory as one packed burst, so that the host sees whole cache lines instead of many small partial updates. Each burst carries the ring index of its first descriptor, the number of descriptors, and the descriptor contents.

A burst is started by one of three triggers. The first is the count of gathered descriptors reaching a programmable threshold. The second is a write-back timer that starts with the first descriptor after the timer has been idle. The third is a software flush command. When the timer expires, the pending descriptors go out first, and only then is a receive-timer interrupt event raised. A descriptor whose buffer address is zero carried no packet data. It is written back with only its done flag set, and it still counts toward the threshold. While one burst waits for the memory side, new descriptors keep collecting in the accumulation bank.

Top module: `rxwb_coalescer`

## Requirements
- R1: A descriptor is taken on a rising edge where `rx_valid` and `rx_ready` are both high. `rx_ready` is low when the accumulation bank holds `MAX_BURST` descriptors, and also in the cycle a burst is being moved out.
- R2: The threshold register is written with `cfg_sel`=1 and is clamped to the range 1..`MAX_BURST`, so a value of 0 or 1 means every descriptor is written back alone. Once the gathered count reaches the threshold, all gathered descriptors leave in one burst, whatever the cache-line alignment. `wb_count` is always between 1 and `MAX_BURST`.
- R3: The delay field is bits [14:0] of a `cfg_sel`=0 write whose bit 15 is clear, and it is counted in ticks of `PRESCALE` cycles. A delay of 0 disables the timer. The timer starts when a descriptor is accepted while the timer is idle. It runs only while descriptors are pending. The burst caused by its expiry appears `delay*PRESCALE+1` cycles after the starting descriptor's accept edge.
- R4: `tmr_irq` is a one-cycle pulse. It is raised only in the cycle in which the burst caused by a timer expiry first appears on `wb_valid`.
- R5: A `cfg_sel`=0 write with bit 15 set flushes every gathered descriptor on the next edge and leaves the stored delay unchanged.
- R6: A descriptor is null when bits [63:0] (its buffer address) are zero. The status byte is bits [103:96], and bit 96 is the done flag. A null descriptor is written back with bit 96 set and all other bits unchanged. Any other descriptor is written back unchanged.
- R7: While `wb_valid` is high and `wb_ready` is low, `wb_valid`, `wb_start`, `wb_count` and `wb_data` hold their values. Descriptor k of a burst is `wb_data[k*128 +: 128]`.
- R8: While a burst waits for `wb_ready`, new descriptors are still accepted into the accumulation bank, up to `MAX_BURST`. A flush that comes due in that time waits until the burst is accepted.
- R9: The first burst after reset starts at index 0. Each later burst starts at the previous start plus the previous count, modulo `RING_SIZE`.
- R10: A flush for any reason stops and clears the timer. The next descriptor starts it again with the full delay.
- R11: If the threshold and a timer expiry are both due together, a single burst is issued and `tmr_irq` is still raised.
- R12: After reset `wb_valid` and `tmr_irq` are low and `rx_ready` is high. The threshold and the delay both reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Completed descriptor offered |
| rx_ready | output | 1 | Descriptor can be taken |
| rx_desc | input | 128 | Completed descriptor |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0: timer register, 1: threshold register |
| cfg_wdata | input | 16 | Register write data |
| wb_valid | output | 1 | Burst offered to memory side |
| wb_ready | input | 1 | Memory side accepts the burst |
| wb_start | output | clog2(RING_SIZE) | Ring index of first descriptor |
| wb_count | output | clog2(MAX_BURST+1) | Descriptors in the burst |
| wb_data | output | MAX_BURST*128 | Burst descriptor contents |
| tmr_irq | output | 1 | Receive-timer interrupt event pulse |

## Verification
The checks that run on every cycle cover the following. A held burst must stay stable. The burst count must stay within bounds. The interrupt must coincide with a burst rising. The timer must run only while descriptors are pending, and a flush must leave it cleared. Accepted descriptors must keep adding to the bank while a burst is held. Other behaviour can only be shown by the bench's scenarios against its reference model. This covers the exact expiry latency, the restart of the timer after a software flush, and a threshold and an expiry landing on the same edge. It also covers the contents of null descriptors and the wrap of the ring index.

// File: rtl/rxwb_pkg.sv
// Shared descriptor type and field positions for the write-back coalescer.
package rxwb_pkg;
    localparam int DESC_W   = 128;
    localparam int ADDR_W   = 64;   // buffer address occupies bits [63:0]
    localparam int DONE_BIT = 96;   // bit 0 of the status byte [103:96]

    typedef logic [DESC_W-1:0] desc_t;

    // Null descriptors (zero buffer address) get only their done flag set.
    function automatic desc_t fix_null(desc_t d);
        desc_t r;
        r = d;
        if (d[ADDR_W-1:0] == '0) r[DONE_BIT] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/rxwb_timer.sv
// Write-back timer: counts a programmed number of prescaled ticks after a
// start request and then raises a sticky expired flag.
// Assumes start_i and stop_i are never both high.
// stop_i clears everything, and a delay of zero never starts the timer.
module rxwb_timer #(
    parameter int PRESCALE = 4,
    parameter int DLY_W    = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic             running_o,
    output logic             expired_o
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [PRE_W-1:0] pre_q;
    logic [DLY_W-1:0] rem_q;

    // Prescaler and tick countdown; stop wins, start only from idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_o <= 1'b0;
            expired_o <= 1'b0;
            pre_q     <= '0;
            rem_q     <= '0;
        end else if (stop_i) begin
            running_o <= 1'b0;
            expired_o <= 1'b0;
            pre_q     <= '0;
        end else if (start_i && !running_o && !expired_o && delay_i != '0) begin
            running_o <= 1'b1;
            rem_q     <= delay_i;
            pre_q     <= '0;
        end else if (running_o) begin
            if (pre_q == PRE_W'(PRESCALE - 1)) begin
                pre_q <= '0;
                if (rem_q == DLY_W'(1)) begin
                    running_o <= 1'b0;
                    expired_o <= 1'b1;
                end else begin
                    rem_q <= rem_q - 1'b1;
                end
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    p_exp_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |-> !running_o);
    p_rem_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        running_o |-> rem_q != '0);
endmodule

// File: rtl/rxwb_acc.sv
// Accumulation bank: stores up to DEPTH descriptors in arrival order.
// Assumes push_i is never raised when the bank is full or together with clear_i.
module rxwb_acc
    import rxwb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  desc_t                        desc_i,
    input  logic                         clear_i,
    output logic [$clog2(DEPTH+1)-1:0]   cnt_o,
    output logic [DEPTH*DESC_W-1:0]      flat_o
);
    localparam int CNT_W = $clog2(DEPTH+1);

    // Fill level of the bank.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_o <= '0;
        else if (clear_i) cnt_o <= '0;
        else if (push_i)  cnt_o <= cnt_o + 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Slot g captures the descriptor pushed while the fill level equals g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flat_o[g*DESC_W +: DESC_W] <= '0;
            else if (push_i && cnt_o == CNT_W'(g))
                flat_o[g*DESC_W +: DESC_W] <= desc_i;
        end
    end

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> cnt_o < CNT_W'(DEPTH));
    p_push_clear_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && clear_i));
endmodule

// File: rtl/rxwb_coalescer.sv
// Receive descriptor write-back coalescer. It gathers completed descriptors
// and hands them to the memory side as one burst. A burst is triggered by the
// threshold, by the write-back timer, or by a software flush. A second (output)
// bank holds the burst in flight while gathering goes on.
// Assumes the memory side consumes bursts in order.
module rxwb_coalescer
    import rxwb_pkg::*;
#(
    parameter int MAX_BURST = 4,
    parameter int RING_SIZE = 16,
    parameter int PRESCALE  = 4,
    parameter int DLY_W     = 15
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rx_valid,
    output logic                             rx_ready,
    input  logic [127:0]                     rx_desc,
    input  logic                             cfg_we,
    input  logic                             cfg_sel,
    input  logic [15:0]                      cfg_wdata,
    output logic                             wb_valid,
    input  logic                             wb_ready,
    output logic [$clog2(RING_SIZE)-1:0]     wb_start,
    output logic [$clog2(MAX_BURST+1)-1:0]   wb_count,
    output logic [MAX_BURST*128-1:0]         wb_data,
    output logic                             tmr_irq
);
    localparam int CNT_W = $clog2(MAX_BURST+1);
    localparam int IDX_W = $clog2(RING_SIZE);

    logic [15:0]              thr_q;
    logic [DLY_W-1:0]         dly_q;
    logic                     swf_q;
    logic [IDX_W-1:0]         idx_q, idx_nx;
    logic [CNT_W-1:0]         acc_cnt, thr_eff;
    logic [MAX_BURST*128-1:0] acc_flat;
    logic                     tmr_run, tmr_exp;
    logic                     flush_due, do_flush, push;
    logic                     tmr_wr;
    int unsigned              idx_sum;

    // Clamp the threshold register to 1..MAX_BURST.
    always_comb begin
        if (thr_q == '0)                  thr_eff = CNT_W'(1);
        else if (thr_q >= 16'(MAX_BURST)) thr_eff = CNT_W'(MAX_BURST);
        else                              thr_eff = thr_q[CNT_W-1:0];
    end

    // A flush is due for any trigger; it moves out only when the output bank is free.
    always_comb begin
        flush_due = (acc_cnt != '0) && ((acc_cnt >= thr_eff) || tmr_exp || swf_q);
        do_flush  = flush_due && !wb_valid;
        rx_ready  = (acc_cnt < CNT_W'(MAX_BURST)) && !do_flush;
        push      = rx_valid && rx_ready;
        tmr_wr    = cfg_we && !cfg_sel;
    end

    // Ring index of the next burst, wrapping at RING_SIZE.
    always_comb begin
        idx_sum = int'(idx_q) + int'(acc_cnt);
        if (idx_sum >= RING_SIZE) idx_sum = idx_sum - RING_SIZE;
        idx_nx = IDX_W'(idx_sum);
    end

    // Configuration registers and the pending software flush request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= '0;
            dly_q <= '0;
            swf_q <= 1'b0;
        end else begin
            if (cfg_we && cfg_sel) thr_q <= cfg_wdata;
            if (tmr_wr && !cfg_wdata[15]) dly_q <= cfg_wdata[DLY_W-1:0];
            if (tmr_wr && cfg_wdata[15])          swf_q <= 1'b1;
            else if (do_flush || acc_cnt == '0)   swf_q <= 1'b0;
        end
    end

    rxwb_acc #(.DEPTH(MAX_BURST)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .desc_i  (fix_null(rx_desc)),
        .clear_i (do_flush),
        .cnt_o   (acc_cnt),
        .flat_o  (acc_flat)
    );

    rxwb_timer #(.PRESCALE(PRESCALE), .DLY_W(DLY_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (push),
        .stop_i    (do_flush),
        .delay_i   (dly_q),
        .running_o (tmr_run),
        .expired_o (tmr_exp)
    );

    // Output bank: load on flush, hold until the memory side accepts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_start <= '0;
            wb_count <= '0;
            wb_data  <= '0;
            idx_q    <= '0;
            tmr_irq  <= 1'b0;
        end else begin
            tmr_irq <= do_flush && tmr_exp;
            if (do_flush) begin
                wb_valid <= 1'b1;
                wb_start <= idx_q;
                wb_count <= acc_cnt;
                wb_data  <= acc_flat;
                idx_q    <= idx_nx;
            end else if (wb_valid && wb_ready) begin
                wb_valid <= 1'b0;
            end
        end
    end

    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_start)
                                  && $stable(wb_count) && $stable(wb_data));
    p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_count != '0 && wb_count <= CNT_W'(MAX_BURST));
    p_irq_on_burst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_irq |-> $rose(wb_valid));
    p_timer_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_run |-> acc_cnt != '0);
    p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        do_flush |=> !tmr_run && !tmr_exp);
    p_gather_in_flight_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready && push |=> acc_cnt == $past(acc_cnt) + 1'b1);
endmodule

// File: tb/test_rxwb_coalescer.sv
module test_rxwb_coalescer;
    localparam int MAXB = 4;
    localparam int RING = 16;
    localparam int PRE  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0;
    logic rx_ready;
    logic [127:0] rx_desc = '0;
    logic cfg_we = 1'b0;
    logic cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic wb_valid;
    logic mem_rdy = 1'b1;
    logic [3:0] wb_start;
    logic [2:0] wb_count;
    logic [MAXB*128-1:0] wb_data;
    logic tmr_irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rxwb_coalescer i_rxwb_coalescer (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_desc(rx_desc), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .wb_valid(wb_valid), .wb_ready(mem_rdy), .wb_start(wb_start),
        .wb_count(wb_count), .wb_data(wb_data), .tmr_irq(tmr_irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [127:0] m_acc[$];
    logic [127:0] m_out[MAXB];
    bit m_wbv, m_irq, m_swf, m_run, m_exp;
    int m_start, m_cnt, m_idx, m_thr, m_dly, m_pre, m_rem;

    function automatic bit m_flush();
        int te;
        te = (m_thr == 0) ? 1 : ((m_thr > MAXB) ? MAXB : m_thr);
        return (m_acc.size() > 0) && (m_acc.size() >= te || m_exp || m_swf) && !m_wbv;
    endfunction

    function automatic bit m_ready();
        return (m_acc.size() < MAXB) && !m_flush();
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc.delete();
            m_wbv = 0; m_irq = 0; m_swf = 0; m_run = 0; m_exp = 0;
            m_start = 0; m_cnt = 0; m_idx = 0; m_thr = 0; m_dly = 0; m_pre = 0; m_rem = 0;
        end else begin
            int n;
            bit fl, acc;
            logic [127:0] d;
            n = m_acc.size();
            fl = m_flush();
            acc = rx_valid && m_ready();
            m_irq = fl && m_exp;
            // timer uses the delay stored before this edge
            if (fl) begin
                m_run = 0; m_exp = 0; m_pre = 0;
            end else if (acc && !m_run && !m_exp && m_dly != 0) begin
                m_run = 1; m_rem = m_dly; m_pre = 0;
            end else if (m_run) begin
                if (m_pre == PRE - 1) begin
                    m_pre = 0;
                    m_rem--;
                    if (m_rem == 0) begin m_run = 0; m_exp = 1; end
                end else m_pre++;
            end
            if (cfg_we && !cfg_sel && cfg_wdata[15]) m_swf = 1;
            else if (fl || n == 0) m_swf = 0;
            if (cfg_we && cfg_sel) m_thr = cfg_wdata;
            if (cfg_we && !cfg_sel && !cfg_wdata[15]) m_dly = cfg_wdata[14:0];
            if (fl) begin
                for (int i = 0; i < n; i++) m_out[i] = m_acc[i];
                m_wbv = 1; m_start = m_idx; m_cnt = n;
                m_idx = (m_idx + n) % RING;
                m_acc.delete();
            end else if (m_wbv && mem_rdy) m_wbv = 0;
            if (acc) begin
                d = rx_desc;
                if (d[63:0] == 64'h0) d[96] = 1'b1;
                m_acc.push_back(d);
            end
        end
    end

    // compare against the model on every clock, away from the active edge
    bit prev_wbv = 0;
    int bursts = 0, irqs = 0, last_cnt = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(rx_ready == m_ready(), "R1", "rx_ready", 128'(rx_ready), 128'(m_ready()));
            chk(wb_valid == m_wbv, "R7", "wb_valid", 128'(wb_valid), 128'(m_wbv));
            chk(tmr_irq == m_irq, "R4", "tmr_irq", 128'(tmr_irq), 128'(m_irq));
            if (wb_valid && m_wbv) begin
                chk(int'(wb_start) == m_start, "R9", "wb_start", 128'(wb_start), 128'(m_start));
                chk(int'(wb_count) == m_cnt, "R2", "wb_count", 128'(wb_count), 128'(m_cnt));
                for (int i = 0; i < m_cnt; i++)
                    chk(wb_data[i*128 +: 128] === m_out[i], "R6", "wb_data slot",
                        wb_data[i*128 +: 128], m_out[i]);
            end
            if (wb_valid && !prev_wbv) begin bursts++; last_cnt = int'(wb_count); end
            if (tmr_irq) irqs++;
            prev_wbv = wb_valid;
        end
    end

    // ---------------- stimulus helpers (called at a negedge) ----------------
    function automatic logic [127:0] mk(input int k, input bit nul);
        logic [127:0] d;
        d[127:64] = {32'hC0DE_0000 | (k << 8), 32'h5A00_0000 | k};
        d[63:0]   = nul ? 64'h0 : {32'h1000_0000 + k, 32'h0000_2000 + k};
        return d;
    endfunction

    task automatic send(input logic [127:0] d);
        rx_valid = 1'b1;
        rx_desc = d;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic cfg(input bit sel, input logic [15:0] v);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(output int cyc);
        cyc = 0;
        while (!tmr_irq && cyc < 200) begin @(negedge clk); cyc++; end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int b0, i0, cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(rx_ready == 1'b1, "R12", "rx_ready after reset", 128'(rx_ready), 128'(1));
        chk(wb_valid == 1'b0, "R12", "wb_valid after reset", 128'(wb_valid), 128'(0));
        chk(tmr_irq == 1'b0, "R12", "tmr_irq after reset", 128'(tmr_irq), 128'(0));

        // R2: threshold 0 => every descriptor alone
        b0 = bursts;
        send(mk(1, 0)); send(mk(2, 1)); send(mk(3, 0));
        idle(6);
        chk(bursts - b0 == 3, "R2", "single bursts", 128'(bursts - b0), 128'(3));

        // R2/R6: threshold 4 with nulls mixed in
        cfg(1'b1, 16'd4);
        b0 = bursts;
        send(mk(4, 1)); send(mk(5, 0)); send(mk(6, 1)); send(mk(7, 0));
        idle(4);
        chk(bursts - b0 == 1, "R2", "packed burst", 128'(bursts - b0), 128'(1));
        chk(last_cnt == 4, "R2", "packed count", 128'(last_cnt), 128'(4));

        // R8: gathering continues while a burst is held
        cfg(1'b1, 16'd2);
        mem_rdy = 1'b0;
        b0 = bursts;
        send(mk(8, 0)); send(mk(9, 0));
        idle(2);
        for (int k = 10; k < 14; k++) send(mk(k, k[0]));
        idle(1);
        chk(rx_ready == 1'b0, "R8", "bank full stalls", 128'(rx_ready), 128'(0));
        mem_rdy = 1'b1;
        idle(6);
        chk(bursts - b0 == 2, "R8", "two bursts", 128'(bursts - b0), 128'(2));
        chk(last_cnt == 4, "R8", "second burst count", 128'(last_cnt), 128'(4));

        // R3/R4: timer expiry latency
        cfg(1'b1, 16'd4);
        cfg(1'b0, 16'd3);
        i0 = irqs;
        send(mk(20, 0));
        wait_irq(cyc);
        chk(cyc == 3 * PRE + 1, "R3", "expiry latency", 128'(cyc), 128'(3 * PRE + 1));
        idle(3);
        chk(irqs - i0 == 1, "R4", "one irq", 128'(irqs - i0), 128'(1));

        // R5: software flush with timer disabled
        cfg(1'b0, 16'd0);
        b0 = bursts;
        send(mk(21, 0)); send(mk(22, 1));
        idle(5);
        chk(bursts - b0 == 0, "R3", "disabled timer holds", 128'(bursts - b0), 128'(0));
        cfg(1'b0, 16'h8000);
        idle(3);
        chk(bursts - b0 == 1, "R5", "sw flush burst", 128'(bursts - b0), 128'(1));
        chk(last_cnt == 2, "R5", "sw flush count", 128'(last_cnt), 128'(2));
        send(mk(23, 0));
        idle(20);
        chk(bursts - b0 == 1, "R5", "delay kept at 0", 128'(bursts - b0), 128'(1));
        cfg(1'b0, 16'h8000);
        idle(3);

        // R10: flush clears timer, next start uses full delay
        cfg(1'b0, 16'd3);
        i0 = irqs;
        send(mk(24, 0));
        idle(6);
        cfg(1'b0, 16'h8000);
        idle(4);
        chk(irqs - i0 == 0, "R10", "no irq after sw flush", 128'(irqs - i0), 128'(0));
        send(mk(25, 0));
        wait_irq(cyc);
        chk(cyc == 3 * PRE + 1, "R10", "fresh delay", 128'(cyc), 128'(3 * PRE + 1));
        idle(3);

        // R11: threshold and expiry on the same edge
        cfg(1'b1, 16'd2);
        cfg(1'b0, 16'd1);
        b0 = bursts; i0 = irqs;
        send(mk(26, 0));
        idle(3);
        send(mk(27, 1));
        idle(4);
        chk(bursts - b0 == 1, "R11", "single burst", 128'(bursts - b0), 128'(1));
        chk(last_cnt == 2, "R11", "burst count", 128'(last_cnt), 128'(2));
        chk(irqs - i0 == 1, "R11", "irq still raised", 128'(irqs - i0), 128'(1));

        // R9: more traffic to wrap the ring index
        for (int k = 30; k < 40; k++) send(mk(k, (k % 3) == 0));
        idle(20);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule